// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

A synchronous single-port memory with a pipelined, zero-bus-turnaround command interface. On every rising clock edge that is not stalled, the block decodes a command word. Its fields are chip enable, advance/load, write enable and a per-lane byte-write mask. A command either opens a new access at an external address or continues the previous access type at an address generated inside the block. Read data and write data both use the data bus in the same slot, two active edges after the address. This lets a read follow a write on the very next cycle without an idle cycle.

Internally a small sequencer holds the burst state: `BST_IDLE`, `BST_READ` or `BST_WRITE`. Its transitions are as follows. A load with chip enable inactive (the deselect transition) enters `BST_IDLE`. A load with chip enable active enters `BST_READ` (load-read) or `BST_WRITE` (load-write) and records the start address. An advance keeps the current state and steps a 2-bit burst counter, or does nothing in `BST_IDLE`. A stall edge changes nothing. A two-slot pipeline carries each access to its data slot. The data bus is split into an input, an output and an output enable, as is usual for on-chip logic.

Top module: `zt_burst_sram`

## Requirements
- R1: While reset is asserted and in the first cycles after it, `dq_oe` is low whatever `oe_n` is, and no access is pending.
- R2: An edge with `cen_n` high is ignored. The pipeline slots, the burst state, the burst counter and the memory contents hold, and the stalled edge is not counted as one of the two edges of any access.
- R3: A load with `ce_n` low and `we_n` high reads the word at `addr`. `dq_o` carries that word with `dq_oe` high during the cycle that ends at the second active edge after the address edge, provided `oe_n` is low.
- R4: A load with `ce_n` low and `we_n` low writes `dq_i`, as sampled at the second active edge after the address edge. Lane i covers bits [8i+7:8i] and is written only when `bw_n[i]` is 0 in the address cycle.
- R5: A load with `ce_n` high (deselect) performs no access, and its data slot has `dq_oe` low.
- R6: An advance (`adv_ld`=1) ignores `ce_n` and `we_n` and repeats the type of the access that opened the burst.
- R7: With `burst_ilv`=0, the low two address bits of successive burst beats count up modulo 4 from the start value, e.g. 01, 10, 11, 00.
- R8: With `burst_ilv`=1, beat k uses the start value XOR k on the low two bits, e.g. start 01 gives 01, 00, 11, 10.
- R9: During a burst the address bits above bit 1 stay at their start value, so the burst wraps inside its aligned group of four words.
- R10: An advance issued in `BST_IDLE` (after reset or a deselect) performs no access and gives no drive in its slot.
- R11: `dq_oe` is high only when the current data slot holds a read and `oe_n` is low.
- R12: A read issued on the cycle after a write to the same address returns the newly written data, with no idle cycle between them.
- R13: In a burst write, each beat updates only the lanes whose `bw_n` bits are 0 in that beat's own command cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen_n | input | 1 | Clock enable, active low; high stalls the edge |
| ce_n | input | 1 | Chip enable for load commands, active low |
| adv_ld | input | 1 | 1 = advance burst, 0 = load external address |
| we_n | input | 1 | Write enable for load commands, active low |
| bw_n | input | LANES (4) | Byte-write selects, active low, bit i = lane i |
| burst_ilv | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| addr | input | AW (6) | External word address |
| oe_n | input | 1 | Output enable, active low |
| dq_i | input | LANES*BYTE_W (32) | Write data from the bus |
| dq_o | output | LANES*BYTE_W (32) | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable for `dq_o` |

## Verification
The memory is first filled by write bursts, so every later read has a known value. Directed sequences then isolate single effects:
- a read right after a write to the same word, which separates correct two-slot write timing from a one-slot or three-slot skew;
- linear and interleaved bursts from start values where the two orders differ, and a start of 11, which exposes a carry into the upper bits;
- advances issued while idle, and advances carrying a different chip enable or write enable than the burst;
- stalls placed between an address and its data slot.

A long seeded random stream then mixes stalls, deselects, mode changes and output-enable toggles against a bench reference model. The random stream catches interactions that the directed cases do not order.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    // Burst sequencer state: what an advance command repeats
    typedef enum logic [1:0] {
        BST_IDLE  = 2'd0,
        BST_READ  = 2'd1,
        BST_WRITE = 2'd2
    } bst_e;

    // Low two address bits of burst beat `step` from `start`
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       ilv);
        return ilv ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
    import zt_sram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             ce_n,
    input  logic             adv_ld,
    input  logic             we_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             ilv,
    input  logic [AW-1:0]    addr,
    output bst_e             state,
    output logic             iss_v,
    output logic             iss_w,
    output logic [AW-1:0]    iss_a,
    output logic [LANES-1:0] iss_b
);

    bst_e          state_d;
    logic [AW-1:0] base_q, base_d;
    logic [1:0]    cnt_q, cnt_d;

    // Next-state decode
    always_comb begin
        state_d = state;
        base_d  = base_q;
        cnt_d   = cnt_q;
        if (act) begin
            if (!adv_ld) begin
                if (ce_n) begin
                    state_d = BST_IDLE;
                end else begin
                    state_d = we_n ? BST_READ : BST_WRITE;
                    base_d  = addr;
                    cnt_d   = '0;
                end
            end else begin
                unique case (state)
                    BST_IDLE:             ;
                    BST_READ, BST_WRITE:  cnt_d = cnt_q + 2'd1;
                    default:              state_d = BST_IDLE;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= BST_IDLE;
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            state  <= state_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    // Access issued by the current command
    always_comb begin
        iss_v = 1'b0;
        iss_w = 1'b0;
        iss_a = addr;
        iss_b = ~bw_n;
        if (adv_ld) begin
            unique case (state)
                BST_IDLE: ;
                BST_READ, BST_WRITE: begin
                    iss_v = 1'b1;
                    iss_w = (state == BST_WRITE);
                    iss_a = {base_q[AW-1:2],
                             burst_low(base_q[1:0], cnt_q + 2'd1, ilv)};
                end
                default: ;
            endcase
        end else if (!ce_n) begin
            iss_v = 1'b1;
            iss_w = !we_n;
        end
    end

endmodule

// File: rtl/zt_slot_pipe.sv
module zt_slot_pipe #(
    parameter int AW    = 6,
    parameter int LANES = 4,
    parameter int STG   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act,
    input  logic             in_v,
    input  logic             in_w,
    input  logic [AW-1:0]    in_a,
    input  logic [LANES-1:0] in_b,
    output logic             s1_v,
    output logic             s1_w,
    output logic [AW-1:0]    s1_a,
    output logic             s2_v,
    output logic             s2_w,
    output logic [AW-1:0]    s2_a,
    output logic [LANES-1:0] s2_b
);

    logic             v_q [STG];
    logic             w_q [STG];
    logic [AW-1:0]    a_q [STG];
    logic [LANES-1:0] b_q [STG];

    for (genvar g = 0; g < STG; g++) begin : g_stage
        logic             v_n, w_n;
        logic [AW-1:0]    a_n;
        logic [LANES-1:0] b_n;
        if (g == 0) begin : g_head
            assign v_n = in_v;
            assign w_n = in_w;
            assign a_n = in_a;
            assign b_n = in_b;
        end else begin : g_tail
            assign v_n = v_q[g-1];
            assign w_n = w_q[g-1];
            assign a_n = a_q[g-1];
            assign b_n = b_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q[g] <= 1'b0;
                w_q[g] <= 1'b0;
                a_q[g] <= '0;
                b_q[g] <= '0;
            end else if (act) begin
                v_q[g] <= v_n;
                w_q[g] <= w_n;
                a_q[g] <= a_n;
                b_q[g] <= b_n;
            end
        end
    end

    assign s1_v = v_q[0];
    assign s1_w = w_q[0];
    assign s1_a = a_q[0];
    assign s2_v = v_q[STG-1];
    assign s2_w = w_q[STG-1];
    assign s2_a = a_q[STG-1];
    assign s2_b = b_q[STG-1];

endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           a,
    input  logic [LANES-1:0]        be,
    input  logic [LANES*BYTE_W-1:0] wd,
    output logic [LANES*BYTE_W-1:0] rd
);

    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BYTE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we && be[l]) mem[a] <= wd[l*BYTE_W +: BYTE_W];
        end
        assign rd[l*BYTE_W +: BYTE_W] = mem[a];
    end

endmodule

// File: rtl/zt_burst_sram.sv
module zt_burst_sram
    import zt_sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cen_n,
    input  logic                    ce_n,
    input  logic                    adv_ld,
    input  logic                    we_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    burst_ilv,
    input  logic [AW-1:0]           addr,
    input  logic                    oe_n,
    input  logic [LANES*BYTE_W-1:0] dq_i,
    output logic [LANES*BYTE_W-1:0] dq_o,
    output logic                    dq_oe
);

    localparam int DW = LANES * BYTE_W;

    logic             act;
    bst_e             bst;
    logic             iss_v, iss_w;
    logic [AW-1:0]    iss_a;
    logic [LANES-1:0] iss_b;
    logic             s1_v, s1_w, s2_v, s2_w;
    logic [AW-1:0]    s1_a, s2_a;
    logic [LANES-1:0] s2_b;
    logic [DW-1:0]    rdata;

    assign act = !cen_n;

    zt_burst_seq #(.AW(AW), .LANES(LANES)) u_seq (
        .clk(clk), .rst_n(rst_n), .act(act), .ce_n(ce_n), .adv_ld(adv_ld),
        .we_n(we_n), .bw_n(bw_n), .ilv(burst_ilv), .addr(addr),
        .state(bst), .iss_v(iss_v), .iss_w(iss_w), .iss_a(iss_a), .iss_b(iss_b)
    );

    zt_slot_pipe #(.AW(AW), .LANES(LANES), .STG(2)) u_pipe (
        .clk(clk), .rst_n(rst_n), .act(act),
        .in_v(iss_v), .in_w(iss_w), .in_a(iss_a), .in_b(iss_b),
        .s1_v(s1_v), .s1_w(s1_w), .s1_a(s1_a),
        .s2_v(s2_v), .s2_w(s2_w), .s2_a(s2_a), .s2_b(s2_b)
    );

    zt_lane_array #(.AW(AW), .LANES(LANES), .BYTE_W(BYTE_W)) u_mem (
        .clk(clk), .we(act && s2_v && s2_w), .a(s2_a), .be(s2_b),
        .wd(dq_i), .rd(rdata)
    );

    assign dq_o  = rdata;
    assign dq_oe = s2_v && !s2_w && !oe_n;

endmodule

// File: rtl/zt_burst_sram_chk.sv
module zt_burst_sram_chk
    import zt_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cen_n,
    input logic          ce_n,
    input logic          adv_ld,
    input logic          oe_n,
    input logic          dq_oe,
    input bst_e          bst,
    input logic          s1_v,
    input logic          s1_w,
    input logic [AW-1:0] s1_a,
    input logic          s2_v,
    input logic          s2_w
);

    // R11
    oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(s1_v) && $stable(s1_a) && $stable(s2_v) && $stable(bst));

    // R5
    desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv_ld && ce_n) |=> !s1_v && bst == BST_IDLE);

    // R10
    adv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && bst == BST_IDLE) |=> !s1_v);

    // R6
    adv_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && bst == BST_WRITE) |=> s1_v && s1_w);

    // R9
    burst_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv_ld && bst != BST_IDLE) |=> s1_a[AW-1:2] == $past(s1_a[AW-1:2]));

    // R3
    slot_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && s1_v && !s1_w) |=> s2_v && !s2_w);

endmodule

bind zt_burst_sram zt_burst_sram_chk #(.AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce_n(ce_n), .adv_ld(adv_ld),
    .oe_n(oe_n), .dq_oe(dq_oe), .bst(bst), .s1_v(s1_v), .s1_w(s1_w),
    .s1_a(s1_a), .s2_v(s2_v), .s2_w(s2_w)
);

// File: tb/test_zt_burst_sram.sv
module test_zt_burst_sram;

    localparam int AW    = 6;
    localparam int LANES = 4;
    localparam int DW    = 32;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n, cen_n, ce_n, adv_ld, we_n, burst_ilv, oe_n;
    logic [LANES-1:0] bw_n;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    dq_i, dq_o;
    logic             dq_oe;

    zt_burst_sram #(.AW(AW), .LANES(LANES), .BYTE_W(8)) i_zt_burst_sram (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce_n(ce_n), .adv_ld(adv_ld),
        .we_n(we_n), .bw_n(bw_n), .burst_ilv(burst_ilv), .addr(addr),
        .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string ctx    = "";

    // Reference model
    logic [DW-1:0]    ref_mem [DEPTH];
    logic             m1_v = 0, m1_w = 0, m2_v = 0, m2_w = 0;
    logic [AW-1:0]    m1_a = '0, m2_a = '0, mbase = '0;
    logic [LANES-1:0] m1_b = '0, m2_b = '0;
    int               m1_k = 0, m2_k = 0;   // 0 none, 1 load read, 2 lin beat, 3 ilv beat, 4 write
    int               mst = 0;              // 0 idle, 1 read, 2 write
    logic [1:0]       mcnt = '0;

    function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] k, bit ilv);
        return ilv ? (s ^ k) : (s + k);
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act_v, logic [DW-1:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act_v, exp_v);
        end
    endtask

    task automatic step(bit c_cen, bit c_ce, bit c_adv, bit c_we,
                        logic [LANES-1:0] c_bw, bit c_ilv, logic [AW-1:0] c_a, bit c_oe);
        logic [DW-1:0] wd;
        logic          exp_oe;
        string         tg;
        @(negedge clk);
        cen_n = c_cen; ce_n = c_ce; adv_ld = c_adv; we_n = c_we;
        bw_n = c_bw; burst_ilv = c_ilv; addr = c_a; oe_n = c_oe;
        wd = $urandom;
        dq_i = wd;
        #1;
        exp_oe = m2_v && !m2_w && !c_oe;
        if (ctx != "")                    tg = ctx;
        else if (m2_v && !m2_w && c_oe)   tg = "R11";
        else if (m2_k == 1)               tg = "R3";
        else if (m2_k == 2)               tg = "R7";
        else if (m2_k == 3)               tg = "R8";
        else if (m2_k == 4)               tg = "R4";
        else                              tg = "R5";
        chk(tg, {31'd0, dq_oe}, {31'd0, exp_oe});
        if (exp_oe) chk(tg, dq_o, ref_mem[m2_a]);
        @(posedge clk);
        if (!c_cen) begin
            if (m2_v && m2_w)
                for (int i = 0; i < LANES; i++)
                    if (m2_b[i]) ref_mem[m2_a][8*i +: 8] = wd[8*i +: 8];
            m2_v = m1_v; m2_w = m1_w; m2_a = m1_a; m2_b = m1_b; m2_k = m1_k;
            m1_v = 0; m1_w = 0; m1_k = 0;
            if (c_adv) begin
                if (mst != 0) begin
                    mcnt = mcnt + 2'd1;
                    m1_v = 1;
                    m1_w = (mst == 2);
                    m1_a = {mbase[AW-1:2], exp_low(mbase[1:0], mcnt, c_ilv)};
                    m1_b = ~c_bw;
                    m1_k = m1_w ? 4 : (c_ilv ? 3 : 2);
                end
            end else if (c_ce) begin
                mst = 0;
            end else begin
                m1_v = 1; m1_w = !c_we; m1_a = c_a; m1_b = ~c_bw;
                m1_k = m1_w ? 4 : 1;
                mst = c_we ? 1 : 2; mbase = c_a; mcnt = '0;
            end
        end
    endtask

    task automatic ld_rd(logic [AW-1:0] a);            step(0, 0, 0, 1, 4'hF, 0, a, 0); endtask
    task automatic ld_wr(logic [AW-1:0] a, logic [3:0] b); step(0, 0, 0, 0, b, 0, a, 0); endtask
    task automatic adv(logic [3:0] b, bit ilv);       step(0, 0, 1, 1, b, ilv, '0, 0); endtask
    task automatic desel();                           step(0, 1, 0, 1, 4'hF, 0, '0, 0); endtask
    task automatic stall();                           step(1, 0, 0, 0, 4'h0, 0, '0, 0); endtask

    initial begin
        void'($urandom(32'h5eed));
        rst_n = 0; cen_n = 0; ce_n = 1; adv_ld = 0; we_n = 1;
        bw_n = 4'hF; burst_ilv = 0; addr = '0; oe_n = 0; dq_i = '0;
        // R1: no drive during reset with output enable active
        repeat (3) begin
            @(negedge clk);
            chk("R1", {31'd0, dq_oe}, 32'd0);
        end
        rst_n = 1;
        ctx = "R1"; desel(); adv(4'h0, 0);

        // Fill every word with write bursts (R13 beats, all lanes)
        ctx = "R13";
        for (int g = 0; g < DEPTH / 4; g++) begin
            ld_wr(AW'(g * 4), 4'h0);
            repeat (3) adv(4'h0, 0);
        end
        desel(); desel();

        ctx = "R3";  ld_rd(6'd5); desel(); desel();
        ctx = "R4";  ld_wr(6'd9, 4'b1010); desel(); ld_rd(6'd9); desel(); desel();
        ctx = "R12"; ld_wr(6'd12, 4'h0); ld_rd(6'd12); ld_wr(6'd13, 4'h0); ld_rd(6'd13); desel(); desel();
        ctx = "R13"; ld_wr(6'd16, 4'b1110); adv(4'b1101, 0); adv(4'b0011, 0); adv(4'b1111, 0);
                     ld_rd(6'd16); adv(4'hF, 0); adv(4'hF, 0); adv(4'hF, 0); desel(); desel();
        ctx = "R7";  ld_rd(6'd21); repeat (3) adv(4'hF, 0); desel(); desel();
        ctx = "R8";  ld_rd(6'd21); repeat (3) adv(4'hF, 1); desel(); desel();
        ctx = "R9";  ld_rd(6'd23); repeat (3) adv(4'hF, 0); ld_rd(6'd23); repeat (3) adv(4'hF, 1); desel(); desel();
        ctx = "R6";  ld_rd(6'd30); step(0, 1, 1, 0, 4'h0, 0, 6'd0, 0); step(0, 1, 1, 0, 4'h0, 0, 6'd0, 0);
                     ld_rd(6'd28); desel(); desel();
        ctx = "R10"; desel(); adv(4'h0, 0); adv(4'h0, 1); desel(); desel();
        ctx = "R2";  ld_wr(6'd40, 4'h0); stall(); stall(); adv(4'h0, 0); stall();
                     ld_rd(6'd40); stall(); adv(4'hF, 0); stall(); stall(); desel(); desel();
        ctx = "R11"; ld_rd(6'd2); adv(4'hF, 0); step(0, 0, 1, 1, 4'hF, 0, '0, 1); adv(4'hF, 0); desel(); desel();
        ctx = "R5";  ld_rd(6'd3); desel(); desel(); desel();

        // Seeded random stream; tags come from the slot kind
        ctx = "";
        for (int n = 0; n < 2000; n++) begin
            step($urandom_range(0, 9) == 0, $urandom_range(0, 6) == 0,
                 1'($urandom), 1'($urandom), 4'($urandom), 1'($urandom),
                 AW'($urandom), $urandom_range(0, 9) == 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule